// File: doc/BRIEF.md
# Uplink Code Epoch Shifter

This block sits in a subscriber transmitter and decides when the uplink spreading codes start each period. The goal is that those codes reach a distant receiver aligned with a common reference instant. It runs on a timebase of four ticks per chip of the fastest code, so a quarter chip is one tick. Its outputs are a one-tick code start strobe and a two-bit quarter-chip phase. The user orthogonal, beam PN and beam orthogonal generators all take these same outputs, so every traffic code restarts on the same epoch.

Alignment happens in two steps. In the first step, the block waits for one signed coarse offset, counted in chip cells. A cell is a full, half or quarter chip, chosen by the resolution input. The block delays or advances the code start by that many cells and then switches to tracking. In tracking, it takes small corrections and uses only their sign, so each correction moves the start by at most one cell. While tracking, the source of corrections can be either of two inputs:
- a timing error word received over the downlink signalling path;
- in retention mode, the local downlink traffic tracking error, which follows slow drift in propagation delay.

A correction never cuts a period short in the middle. It is held in a single pending slot and applied only at the next code boundary, where it stretches or shortens that period.

Top module: `code_epoch_shifter`

## Requirements
- R1: After reset, `code_start` is high and `chip_quarter` is 0 in the first cycle. The block is in acquisition. With no correction applied, code starts repeat every 4*PERIOD_CHIPS ticks (64 with defaults).
- R2: The cell size comes from `res_sel` at the cycle a correction is accepted: 0 = one chip (4 ticks), 1 = half chip (2 ticks), 2 or 3 = quarter chip (1 tick).
- R3: In acquisition, a `coarse_valid` pulse with signed `coarse_cells` = x is accepted. The span from the first code start after acceptance to the following one is 64 + x*cell ticks: positive delays, negative advances. The shift saturates at +63 and -63 ticks.
- R4: Once the coarse shift has been applied the block stays in tracking until reset. Any later `coarse_valid` has no effect on code start timing.
- R5: In acquisition, `fine_valid` and `trk_valid` are ignored: period lengths stay at 64.
- R6: In tracking, an accepted error value E moves the next applied period by +1 cell if E > 0, by -1 cell if E < 0, and not at all if E = 0, whatever the magnitude of E.
- R7: In tracking with `retain` low, corrections come from `fine_valid`/`fine_err` and `trk_valid` is ignored. With `retain` high they come from `trk_valid`/`trk_err` and `fine_valid` is ignored.
- R8: At most one correction is pending at a time. A correction is accepted only when the slot is empty or on a code start cycle. A second correction arriving while one is pending is dropped.
- R9: `chip_quarter` is 0 on every code start cycle and otherwise advances by one, modulo 4, each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one tick per quarter chip |
| rst | input | 1 | Synchronous active-high reset |
| res_sel | input | 2 | Chip cell resolution select |
| coarse_valid | input | 1 | Coarse offset strobe |
| coarse_cells | input | CELL_W | Signed coarse offset in cells |
| fine_valid | input | 1 | Remote timing error strobe |
| fine_err | input | ERR_W | Signed remote timing error |
| trk_valid | input | 1 | Local tracking error strobe |
| trk_err | input | ERR_W | Signed local downlink tracking error |
| retain | input | 1 | Selects local tracking as correction source |
| code_start | output | 1 | One-tick code period start strobe |
| chip_quarter | output | 2 | Quarter-chip phase within the current chip |

## Verification
The hardest situation to reach is a second correction landing while the first is still waiting for the boundary. This matters because the dropped word only shows up as the absence of a change one period later. The bench reaches it by offering a correction on a start cycle and a conflicting one on the very next tick. It then measures the period after the following start. Saturation is also awkward to reach, because it only happens in acquisition, which is a single shot per reset. The bench therefore resets between coarse cases. A seeded random run mixes sources, resolutions and error signs in tracking.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int SHIFT_W = 16;

    typedef logic signed [SHIFT_W-1:0] shift_t;

    typedef enum logic [1:0] {
        RES_FULL    = 2'd0,
        RES_HALF    = 2'd1,
        RES_QUART   = 2'd2,
        RES_QUART_B = 2'd3
    } cell_res_e;

    typedef enum logic {
        LOOP_ACQ   = 1'b0,
        LOOP_TRACK = 1'b1
    } loop_mode_e;

    typedef struct packed {
        logic   live;
        shift_t ticks;
    } pend_t;

    function automatic int cell_ticks(cell_res_e r);
        case (r)
            RES_FULL: return 4;
            RES_HALF: return 2;
            default:  return 1;
        endcase
    endfunction

    function automatic shift_t sat_shift(int v, int lim);
        if (v > lim)       return shift_t'(lim);
        else if (v < -lim) return shift_t'(-lim);
        else               return shift_t'(v);
    endfunction

endpackage

// File: rtl/cst_cell_convert.sv
module cst_cell_convert
    import cst_pkg::*;
#(
    parameter int CELL_W    = 8,
    parameter int ERR_W     = 6,
    parameter int MAX_TICKS = 63
) (
    input  logic [1:0]               res_sel,
    input  logic signed [CELL_W-1:0] coarse_cells,
    input  logic signed [ERR_W-1:0]  rem_err,
    input  logic signed [ERR_W-1:0]  loc_err,
    output shift_t                   coarse_ticks,
    output shift_t                   rem_ticks,
    output shift_t                   loc_ticks
);

    int unit;
    int craw;

    function automatic shift_t sign_step(logic signed [ERR_W-1:0] e, int u);
        if (e > 0)      return shift_t'(u);
        else if (e < 0) return shift_t'(-u);
        else            return '0;
    endfunction

    always_comb begin
        unit         = cell_ticks(cell_res_e'(res_sel));
        craw         = int'(coarse_cells) * unit;
        coarse_ticks = sat_shift(craw, MAX_TICKS);
        rem_ticks    = sign_step(rem_err, unit);
        loc_ticks    = sign_step(loc_err, unit);
    end

endmodule

// File: rtl/cst_corr_gate.sv
module cst_corr_gate
    import cst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  logic   coarse_valid,
    input  logic   fine_valid,
    input  logic   trk_valid,
    input  logic   retain,
    input  shift_t coarse_ticks,
    input  shift_t rem_ticks,
    input  shift_t loc_ticks,
    output shift_t apply_ticks,
    output logic   pend_live,
    output logic   accept,
    output logic   tracking
);

    loop_mode_e mode_q;
    pend_t      pend_q;
    logic       room;
    logic       take_coarse;
    logic       take_fine;
    shift_t     fine_pick;

    always_comb begin
        room        = !pend_q.live || strobe;
        take_coarse = (mode_q == LOOP_ACQ) && !pend_q.live && coarse_valid;
        take_fine   = (mode_q == LOOP_TRACK) && room &&
                      (retain ? trk_valid : fine_valid);
        fine_pick   = retain ? loc_ticks : rem_ticks;
        accept      = take_coarse || take_fine;
        apply_ticks = pend_q.live ? pend_q.ticks : '0;
        pend_live   = pend_q.live;
        tracking    = (mode_q == LOOP_TRACK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= LOOP_ACQ;
            pend_q <= '0;
        end else begin
            if (strobe && pend_q.live && mode_q == LOOP_ACQ)
                mode_q <= LOOP_TRACK;
            if (accept)
                pend_q <= '{live: 1'b1, ticks: (take_coarse ? coarse_ticks : fine_pick)};
            else if (strobe)
                pend_q <= '0;
        end
    end

endmodule

// File: rtl/cst_epoch_timer.sv
module cst_epoch_timer
    import cst_pkg::*;
#(
    parameter int PERIOD_CHIPS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  shift_t     apply_ticks,
    output logic       strobe,
    output logic [1:0] quarter
);

    localparam int PT = 4 * PERIOD_CHIPS;
    localparam int CW = $clog2(2 * PT);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [1:0]    ph_q, ph_d;

    always_comb begin
        if (cnt_q == '0)
            cnt_d = CW'(PT - 1 + int'(apply_ticks));
        else
            cnt_d = cnt_q - 1'b1;
        ph_d = (cnt_d == '0) ? 2'd0 : ph_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= 2'd0;
        end else begin
            cnt_q <= cnt_d;
            ph_q  <= ph_d;
        end
    end

    assign strobe  = (cnt_q == '0);
    assign quarter = ph_q;

endmodule

// File: rtl/code_epoch_shifter.sv
module code_epoch_shifter
    import cst_pkg::*;
#(
    parameter int PERIOD_CHIPS = 16,
    parameter int CELL_W       = 8,
    parameter int ERR_W        = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               res_sel,
    input  logic                     coarse_valid,
    input  logic signed [CELL_W-1:0] coarse_cells,
    input  logic                     fine_valid,
    input  logic signed [ERR_W-1:0]  fine_err,
    input  logic                     trk_valid,
    input  logic signed [ERR_W-1:0]  trk_err,
    input  logic                     retain,
    output logic                     code_start,
    output logic [1:0]               chip_quarter
);

    localparam int PT        = 4 * PERIOD_CHIPS;
    localparam int MAX_TICKS = PT - 1;

    shift_t coarse_ticks;
    shift_t rem_ticks;
    shift_t loc_ticks;
    shift_t apply_ticks;
    logic   pend_live;
    logic   accept;
    logic   tracking;
    logic   strobe;

    cst_cell_convert #(
        .CELL_W    (CELL_W),
        .ERR_W     (ERR_W),
        .MAX_TICKS (MAX_TICKS)
    ) u_conv (
        .res_sel      (res_sel),
        .coarse_cells (coarse_cells),
        .rem_err      (fine_err),
        .loc_err      (trk_err),
        .coarse_ticks (coarse_ticks),
        .rem_ticks    (rem_ticks),
        .loc_ticks    (loc_ticks)
    );

    cst_corr_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .strobe       (strobe),
        .coarse_valid (coarse_valid),
        .fine_valid   (fine_valid),
        .trk_valid    (trk_valid),
        .retain       (retain),
        .coarse_ticks (coarse_ticks),
        .rem_ticks    (rem_ticks),
        .loc_ticks    (loc_ticks),
        .apply_ticks  (apply_ticks),
        .pend_live    (pend_live),
        .accept       (accept),
        .tracking     (tracking)
    );

    cst_epoch_timer #(
        .PERIOD_CHIPS (PERIOD_CHIPS)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .apply_ticks (apply_ticks),
        .strobe      (strobe),
        .quarter     (chip_quarter)
    );

    assign code_start = strobe;

endmodule

// File: rtl/cst_epoch_checker.sv
module cst_epoch_checker
    import cst_pkg::*;
#(
    parameter int PERIOD_CHIPS = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       code_start,
    input logic [1:0] chip_quarter,
    input logic       accept,
    input logic       pend_live,
    input logic       tracking,
    input shift_t     apply_ticks
);

    localparam int PT = 4 * PERIOD_CHIPS;
    localparam int GW = $clog2(4 * PT);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)             gap_q <= '0;
        else if (code_start) gap_q <= GW'(1);
        else                 gap_q <= gap_q + 1'b1;
    end

    assert_start_quarter_zero_R9: assert property (@(posedge clk) disable iff (rst)
        code_start |-> chip_quarter == 2'd0);

    assert_quarter_steps_R9: assert property (@(posedge clk) disable iff (rst)
        !code_start |-> chip_quarter == 2'($past(chip_quarter) + 2'd1));

    assert_single_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_live && !code_start && tracking) |-> !accept);

    assert_track_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        tracking |=> tracking);

    assert_fine_step_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (tracking && pend_live) |-> (apply_ticks <= 16'sd4 && apply_ticks >= -16'sd4));

    assert_gap_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        code_start |-> int'(gap_q) <= 2 * PT - 1);

endmodule

bind code_epoch_shifter cst_epoch_checker #(.PERIOD_CHIPS(PERIOD_CHIPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .code_start   (code_start),
    .chip_quarter (chip_quarter),
    .accept       (accept),
    .pend_live    (pend_live),
    .tracking     (tracking),
    .apply_ticks  (apply_ticks)
);

// File: tb/code_epoch_shifter_test.sv
module code_epoch_shifter_test;

    localparam int PC = 16;
    localparam int PT = 4 * PC;
    localparam int CW = 8;
    localparam int EW = 6;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           res_sel = 2'd0;
    logic                 coarse_valid = 1'b0;
    logic signed [CW-1:0] coarse_cells = '0;
    logic                 fine_valid = 1'b0;
    logic signed [EW-1:0] fine_err = '0;
    logic                 trk_valid = 1'b0;
    logic signed [EW-1:0] trk_err = '0;
    logic                 retain = 1'b0;
    logic                 code_start;
    logic [1:0]           chip_quarter;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic done = 1'b0;

    code_epoch_shifter #(.PERIOD_CHIPS(PC), .CELL_W(CW), .ERR_W(EW)) uut (
        .clk, .rst, .res_sel, .coarse_valid, .coarse_cells, .fine_valid,
        .fine_err, .trk_valid, .trk_err, .retain, .code_start, .chip_quarter
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unit_of(int r);
        return (r == 0) ? 4 : (r == 1) ? 2 : 1;
    endfunction

    function automatic int exp_coarse(int r, int x);
        int v = x * unit_of(r);
        if (v > PT - 1) v = PT - 1;
        if (v < -(PT - 1)) v = -(PT - 1);
        return PT + v;
    endfunction

    function automatic int exp_fine(int r, int e);
        return PT + ((e > 0) ? unit_of(r) : (e < 0) ? -unit_of(r) : 0);
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!code_start) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        coarse_valid = 1'b0; fine_valid = 1'b0; trk_valid = 1'b0; retain = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // kind 0 coarse, 1 remote error, 2 local error
    task automatic inject(int kind, int r, int v);
        wait_start();
        res_sel = 2'(r);
        case (kind)
            0: begin coarse_valid = 1'b1; coarse_cells = CW'(v); end
            1: begin fine_valid = 1'b1; fine_err = EW'(v); end
            default: begin trk_valid = 1'b1; trk_err = EW'(v); end
        endcase
        @(negedge clk);
        coarse_valid = 1'b0; fine_valid = 1'b0; trk_valid = 1'b0;
    endtask

    task automatic measure(output int len);
        int b;
        wait_start();
        b = cyc;
        wait_start();
        len = cyc - b;
    endtask

    task automatic coarse_case(string tag, int r, int x);
        int len;
        do_reset();
        inject(0, r, x);
        measure(len);
        check(tag, len, exp_coarse(r, x));
    endtask

    initial begin
        int len;
        int s;
        s = $urandom(32'h5eed);

        // R1 reset state and free-running period
        do_reset();
        check("R1 start after reset", int'(code_start), 1);
        check("R1 quarter after reset", int'(chip_quarter), 0);
        measure(len);
        check("R1 idle period", len, PT);

        // R5 corrections before coarse ignored
        inject(1, 0, 3);
        measure(len);
        check("R5 remote ignored in acq", len, PT);
        inject(2, 0, -3);
        measure(len);
        check("R5 local ignored in acq", len, PT);

        // R9 quarter phase sequence
        wait_start();
        check("R9 quarter at start", int'(chip_quarter), 0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R9 quarter step", int'(chip_quarter), k % 4);
        end

        // R2/R3 coarse at each resolution and saturation
        coarse_case("R3 R2 full chip delay", 0, 3);
        coarse_case("R3 R2 half chip advance", 1, -5);
        coarse_case("R3 R2 quarter delay", 2, 7);
        coarse_case("R2 quarter alt code", 3, -9);
        coarse_case("R3 saturate positive", 0, 100);
        coarse_case("R3 saturate negative", 0, -128);

        // R4 coarse ignored after lock
        do_reset();
        inject(0, 2, 0);
        measure(len);
        check("R4 zero coarse", len, PT);
        inject(0, 0, 5);
        measure(len);
        check("R4 coarse ignored in tracking", len, PT);

        // R6 sign-only fine steps
        inject(1, 0, 5);
        measure(len);
        check("R6 remote positive full", len, exp_fine(0, 5));
        inject(1, 2, -7);
        measure(len);
        check("R6 remote negative quarter", len, exp_fine(2, -7));
        inject(1, 1, 0);
        measure(len);
        check("R6 zero error", len, PT);

        // R7 source selection
        inject(2, 0, 4);
        measure(len);
        check("R7 local ignored when retain low", len, PT);
        retain = 1'b1;
        inject(1, 0, 4);
        measure(len);
        check("R7 remote ignored when retain high", len, PT);
        inject(2, 1, -2);
        measure(len);
        check("R7 local used when retain high", len, exp_fine(1, -2));
        retain = 1'b0;

        // R8 second correction in same period dropped
        wait_start();
        res_sel = 2'd0; fine_valid = 1'b1; fine_err = EW'(1);
        @(negedge clk);
        fine_err = EW'(-1);
        @(negedge clk);
        fine_valid = 1'b0;
        measure(len);
        check("R8 second correction dropped", len, exp_fine(0, 1));

        // random tracking mix
        for (int i = 0; i < 40; i++) begin
            int r = int'($urandom_range(0, 3));
            int e = int'($urandom_range(0, 15)) - 8;
            int sel = int'($urandom_range(0, 3));
            logic rt = 1'($urandom_range(0, 1));
            int exp;
            retain = rt;
            if (sel == 0) begin
                inject(rt ? 1 : 2, r, e);
                exp = PT;
            end else begin
                inject(rt ? 2 : 1, r, e);
                exp = exp_fine(r, e);
            end
            measure(len);
            check(sel == 0 ? "R7 random unselected source" : "R6 random correction", len, exp);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule